// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory instruction into a stream of element addresses, one per cycle. A single start pulse captures the base address, a signed stride, an addressing mode, a load/store flag and the active vector length. The block then walks the element numbers from zero upward and presents one address for each element until the requested count has been issued.

Three addressing modes are supported. In contiguous mode the address advances by one per element. In strided mode it advances by a signed scalar step. In indexed mode each element's offset is read from a vector register through a small read port that the block drives with the current element number. This mode serves gather for loads and scatter for stores. The downstream consumer applies back-pressure with a ready signal: an address leaves only when valid and ready are both high, and a stalled address stays unchanged. A one-cycle completion pulse follows the last accepted address. All address arithmetic is 32 bits wide and wraps on overflow.

Top module: `vmem_agen`

## Requirements
- R1: With mode code 0 (contiguous), or with the spare code 3, which behaves the same way, element i is issued at address base + i, modulo 2^32.
- R2: With mode code 1 (strided), element i is issued at address base + i*stride. The stride is a signed two's-complement 32-bit value and the result wraps modulo 2^32.
- R3: With mode code 2 (indexed), element i is issued at address base + idx_data_i. During element i the index read port `idx_elem_o` presents i.
- R4: A started operation issues exactly min(vl_i, 64) addresses, with `elem_o` running 0, 1, 2, … in order. Any vl_i above 64 is treated as 64, and `addr_valid_o` stays high from the first address to the last.
- R5: While `addr_valid_o` is high and `addr_ready_i` is low, the next cycle shows the same address, element number and store flag, with valid still high.
- R6: `store_o` equals the `is_store_i` value captured at start, for every address of the operation.
- R7: A start with vl_i = 0 issues no address, and `done_o` is high in the cycle after the start.
- R8: `done_o` is high for exactly the one cycle after the last address is accepted, and it never coincides with `addr_valid_o`.
- R9: A start pulse while an operation is still issuing addresses is ignored: the running stream is unchanged, and no extra addresses follow it.
- R10: While reset is asserted and right after it, `addr_valid_o` and `done_o` are low.
- R11: Base, stride, mode, store flag and length are sampled only on an accepted start. Later changes on those inputs do not alter the running stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| mode_i | input | 2 | Addressing mode: 0 contiguous, 1 strided, 2 indexed, 3 contiguous |
| is_store_i | input | 1 | 1 for store (scatter), 0 for load (gather) |
| base_i | input | 32 | Base address |
| stride_i | input | 32 | Signed element stride for strided mode |
| vl_i | input | 8 | Requested vector length; values above 64 clamp to 64 |
| idx_elem_o | output | 6 | Element number presented to the index-vector read port |
| idx_data_i | input | 32 | Index element returned for `idx_elem_o`, same cycle |
| addr_valid_o | output | 1 | Address on `addr_o` is valid |
| addr_ready_i | input | 1 | Consumer accepts the address this cycle |
| addr_o | output | 32 | Element address |
| elem_o | output | 6 | Element number of the current address |
| store_o | output | 1 | Load/store flag of the current address |
| done_o | output | 1 | One-cycle pulse after the final address, or after a zero-length start |

## Verification
Corruption in the element counter shows in the very next cycle as an element number that skips or repeats, or as a stream that ends with the wrong count. Corruption in the running-address register shows as an address that breaks the base + i*stride sequence on the next accepted element. Stimulus mixes randomized ready patterns, negative and wrapping strides, random index vectors and lengths above the maximum. Every address is compared with its closed-form value, and each stall is checked for a held output.

// File: rtl/vmem_agen_pkg.sv
package vmem_agen_pkg;
  // Addressing mode codes as seen on mode_i
  typedef enum logic [1:0] {
    AM_UNIT     = 2'd0,
    AM_STRIDE   = 2'd1,
    AM_INDEX    = 2'd2,
    AM_UNIT_ALT = 2'd3
  } amode_e;

  localparam int unsigned AGEN_ADDR_W = 32;
  localparam int unsigned AGEN_MAX_VL = 64;
  localparam int unsigned AGEN_VLI_W  = 8;
endpackage

// File: rtl/vmem_agen_seq.sv
// Element sequencer: accepts start, clamps the length, counts handshakes,
// and produces the completion pulse.
module vmem_agen_seq #(
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned VLI_W  = 8,
  localparam int unsigned CNT_W = $clog2(MAX_VL) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VLI_W-1:0] vl_i,
  input  logic             fire_i,
  output logic             launch_o,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic             active_q, active_n;
  logic             done_q, done_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] lim_q, lim_n;
  logic [CNT_W-1:0] vl_eff;
  logic [CNT_W-1:0] cnt_inc;
  logic             cnt_en;
  logic             launch;

  assign launch  = start_i && !active_q;
  assign vl_eff  = (vl_i > VLI_W'(MAX_VL)) ? CNT_W'(MAX_VL) : vl_i[CNT_W-1:0];
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign cnt_en  = launch || fire_i;

  always_comb begin
    active_n = active_q;
    done_n   = 1'b0;
    cnt_n    = cnt_q;
    lim_n    = lim_q;
    if (launch) begin
      active_n = (vl_eff != '0);
      done_n   = (vl_eff == '0);
      cnt_n    = '0;
      lim_n    = vl_eff;
    end else if (fire_i) begin
      cnt_n = cnt_inc;
      if (cnt_inc == lim_q) begin
        active_n = 1'b0;
        done_n   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_n;
      done_q   <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
      lim_q <= lim_n;
    end
  end

  assign launch_o = launch;
  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign done_o   = done_q;
endmodule

// File: rtl/vmem_agen_addr.sv
// Address datapath: captures operands at launch and forms the element address.
module vmem_agen_addr
  import vmem_agen_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned CNT_W    = 7,
  parameter bit          USE_MULT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              fire_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  amode_e            mode_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [ADDR_W-1:0] idx_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              store_o,
  output amode_e            mode_o,
  output logic [ADDR_W-1:0] stride_o
);
  amode_e            mode_q;
  logic              store_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] stride_q;
  logic [ADDR_W-1:0] lin_addr;
  logic [ADDR_W-1:0] step;

  assign step = (mode_q == AM_STRIDE) ? stride_q : ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= AM_UNIT;
      store_q  <= 1'b0;
      base_q   <= '0;
      stride_q <= '0;
    end else if (launch_i) begin
      mode_q   <= mode_i;
      store_q  <= store_i;
      base_q   <= base_i;
      stride_q <= stride_i;
    end
  end

  generate
    if (USE_MULT) begin : g_mul
      // Closed-form offset: one multiplier, no running state
      logic [ADDR_W-1:0] cnt_ext;
      assign cnt_ext  = {{(ADDR_W-CNT_W){1'b0}}, cnt_i};
      assign lin_addr = base_q + step * cnt_ext;
    end else begin : g_run
      // Running accumulator: one adder, advanced on each handshake
      logic [ADDR_W-1:0] run_q, run_n;
      logic              run_en;
      assign run_en = launch_i || fire_i;
      assign run_n  = launch_i ? base_i : (run_q + step);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q <= '0;
        end else if (run_en) begin
          run_q <= run_n;
        end
      end
      assign lin_addr = run_q;
    end
  endgenerate

  assign addr_o   = (mode_q == AM_INDEX) ? (base_q + idx_data_i) : lin_addr;
  assign store_o  = store_q;
  assign mode_o   = mode_q;
  assign stride_o = stride_q;
endmodule

// File: rtl/vmem_agen.sv
module vmem_agen
  import vmem_agen_pkg::*;
#(
  parameter int unsigned ADDR_W   = AGEN_ADDR_W,
  parameter int unsigned MAX_VL   = AGEN_MAX_VL,
  parameter int unsigned VLI_W    = AGEN_VLI_W,
  parameter bit          USE_MULT = 1'b0,
  localparam int unsigned EL_W    = $clog2(MAX_VL),
  localparam int unsigned CNT_W   = EL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              is_store_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VLI_W-1:0]  vl_i,
  output logic [EL_W-1:0]   idx_elem_o,
  input  logic [ADDR_W-1:0] idx_data_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [EL_W-1:0]   elem_o,
  output logic              store_o,
  output logic              done_o
);
  logic             launch;
  logic             active;
  logic             fire;
  logic [CNT_W-1:0] cnt;
  amode_e           mode_q;
  logic [ADDR_W-1:0] stride_q;

  assign fire = active && addr_ready_i;

  vmem_agen_seq #(
    .MAX_VL (MAX_VL),
    .VLI_W  (VLI_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .fire_i   (fire),
    .launch_o (launch),
    .active_o (active),
    .cnt_o    (cnt),
    .done_o   (done_o)
  );

  vmem_agen_addr #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .USE_MULT (USE_MULT)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_i   (launch),
    .fire_i     (fire),
    .cnt_i      (cnt),
    .mode_i     (amode_e'(mode_i)),
    .store_i    (is_store_i),
    .base_i     (base_i),
    .stride_i   (stride_i),
    .idx_data_i (idx_data_i),
    .addr_o     (addr_o),
    .store_o    (store_o),
    .mode_o     (mode_q),
    .stride_o   (stride_q)
  );

  assign addr_valid_o = active;
  assign elem_o       = cnt[EL_W-1:0];
  assign idx_elem_o   = cnt[EL_W-1:0];
endmodule

// File: rtl/vmem_agen_chk.sv
module vmem_agen_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EL_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid_o,
  input logic              addr_ready_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [EL_W-1:0]   elem_o,
  input logic              store_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] idx_data_i,
  input logic [1:0]        mode_q,
  input logic [ADDR_W-1:0] stride_q
);
  logic fire;
  assign fire = addr_valid_o && addr_ready_i;

  // R10: idle outputs during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r10: assert (!addr_valid_o && !done_o)
        else $error("reset idle violated");
    end
  end

  // R5: stalled address held
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i) |=>
      (addr_valid_o && $stable(elem_o) && $stable(store_o) &&
       (!$stable(idx_data_i) || $stable(addr_o))));

  // R4: element numbers advance by one until completion
  p_elem_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((addr_valid_o && elem_o == $past(elem_o) + EL_W'(1)) ||
              (!addr_valid_o && done_o)));

  // R4: every stream begins at element zero
  p_first_elem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid_o) |-> (elem_o == '0));

  // R1: contiguous mode advances by one
  p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (mode_q == 2'd0 || mode_q == 2'd3)) |=>
      (!addr_valid_o || addr_o == $past(addr_o) + ADDR_W'(1)));

  // R2: strided mode advances by the captured stride
  p_stride_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_q == 2'd1) |=>
      (!addr_valid_o || addr_o == $past(addr_o) + stride_q));

  // R8: completion never overlaps a valid address
  p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !addr_valid_o);
endmodule

bind vmem_agen vmem_agen_chk #(
  .ADDR_W (ADDR_W),
  .EL_W   (EL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_valid_o (addr_valid_o),
  .addr_ready_i (addr_ready_i),
  .addr_o       (addr_o),
  .elem_o       (elem_o),
  .store_o      (store_o),
  .done_o       (done_o),
  .idx_data_i   (idx_data_i),
  .mode_q       (mode_q),
  .stride_q     (stride_q)
);

// File: tb/vmem_agen_test.sv
`timescale 1ns/1ps
module vmem_agen_test;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  mode_i;
  logic        is_store_i;
  logic [31:0] base_i;
  logic [31:0] stride_i;
  logic [7:0]  vl_i;
  logic [5:0]  idx_elem_o;
  logic [31:0] idx_data_i;
  logic        addr_valid_o;
  logic        addr_ready_i;
  logic [31:0] addr_o;
  logic [5:0]  elem_o;
  logic        store_o;
  logic        done_o;

  logic [31:0] idx_mem [64];
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  assign idx_data_i = idx_mem[idx_elem_o];

  vmem_agen uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .is_store_i(is_store_i), .base_i(base_i), .stride_i(stride_i),
    .vl_i(vl_i), .idx_elem_o(idx_elem_o), .idx_data_i(idx_data_i),
    .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i),
    .addr_o(addr_o), .elem_o(elem_o), .store_o(store_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [1:0] m,
      input logic [31:0] b, input logic [31:0] s, input int k);
    case (m)
      2'd1:    return b + s * 32'(k);
      2'd2:    return b + idx_mem[k];
      default: return b + 32'(k);
    endcase
  endfunction

  task automatic fill_idx();
    for (int i = 0; i < 64; i++) idx_mem[i] = $urandom;
  endtask

  task automatic run_op(input logic [1:0] m, input bit st, input logic [31:0] b,
                        input logic [31:0] s, input logic [7:0] vl,
                        input int rdy_pct, input bit poke);
    int n;
    int k;
    int it;
    bit stalled;
    bit poked;
    bit ended;
    logic [31:0] prev_addr;
    logic [5:0]  prev_elem;
    string tag;
    n = (vl > 8'd64) ? 64 : int'(vl);
    tag = (m == 2'd1) ? "R2 (R11 held operands)" :
          (m == 2'd2) ? "R3 (R11 held operands)" : "R1 (R11 held operands)";
    @(negedge clk);
    mode_i = m; is_store_i = st; base_i = b; stride_i = s; vl_i = vl;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R11: scramble operand inputs after the start edge
    base_i = $urandom; stride_i = $urandom; mode_i = 2'($urandom);
    vl_i = 8'($urandom); is_store_i = ~st;
    k = 0; stalled = 0; poked = 0; ended = 0; prev_addr = '0; prev_elem = '0;
    for (it = 0; it < 3000; it++) begin
      if (n == 0) begin
        chk(done_o && !addr_valid_o, "R7 zero length done", {30'd0, done_o, addr_valid_o}, 32'h2);
        ended = 1;
        break;
      end
      if (done_o) begin
        chk(k == n && !addr_valid_o, "R4 issued count", 32'(k), 32'(n));
        ended = 1;
        break;
      end
      if (addr_valid_o) begin
        chk(addr_o == exp_addr(m, b, s, k), tag, addr_o, exp_addr(m, b, s, k));
        chk(elem_o == 6'(k), "R4 element order", 32'(elem_o), 32'(k));
        chk(store_o == st, "R6 store flag", 32'(store_o), 32'(st));
        if (m == 2'd2)
          chk(idx_elem_o == 6'(k), "R3 index port element", 32'(idx_elem_o), 32'(k));
        if (stalled)
          chk(addr_o == prev_addr && elem_o == prev_elem, "R5 stall hold", addr_o, prev_addr);
      end else begin
        chk(1'b0, "R4 valid dropped before done", 32'(k), 32'(n));
      end
      if (poke && k == 2 && !poked) begin
        // R9: start while busy with different operands
        start_i = 1'b1; mode_i = 2'd1; vl_i = 8'd3;
        base_i = 32'hDEAD_0000; stride_i = 32'h40;
        poked = 1;
      end else begin
        start_i = 1'b0;
      end
      addr_ready_i = ($urandom_range(99) < rdy_pct);
      stalled   = addr_valid_o && !addr_ready_i;
      prev_addr = addr_o;
      prev_elem = elem_o;
      if (addr_valid_o && addr_ready_i) k++;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (!ended) chk(1'b0, "R4 operation never completed", 32'(k), 32'(n));
    addr_ready_i = 1'b1;
    @(negedge clk);
    chk(!addr_valid_o && !done_o, "R8 R9 single done pulse, no extra stream",
        {30'd0, addr_valid_o, done_o}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; start_i = 0; mode_i = 0; is_store_i = 0; base_i = 0;
    stride_i = 0; vl_i = 0; addr_ready_i = 0;
    fill_idx();
    repeat (3) @(negedge clk);
    chk(!addr_valid_o && !done_o, "R10 reset idle", {30'd0, addr_valid_o, done_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!addr_valid_o && !done_o, "R10 idle after reset", {30'd0, addr_valid_o, done_o}, 32'h0);

    run_op(2'd0, 1'b0, 32'h0000_1000, 32'h0, 8'd8, 100, 0);          // R1
    run_op(2'd1, 1'b1, 32'h0000_2000, -32'sd12, 8'd16, 60, 0);       // R2 negative
    run_op(2'd1, 1'b0, 32'hFFFF_FFF0, 32'h10, 8'd5, 100, 0);         // R2 wrap
    run_op(2'd0, 1'b1, 32'hFFFF_FFFC, 32'h0, 8'd8, 70, 0);           // R1 wrap
    run_op(2'd2, 1'b0, 32'h0000_4000, 32'h0, 8'd20, 50, 0);          // R3 gather
    fill_idx();
    run_op(2'd2, 1'b1, 32'h8000_0000, 32'h0, 8'd64, 30, 0);          // R3 scatter
    run_op(2'd0, 1'b0, 32'h0000_0100, 32'h4, 8'd0, 100, 0);          // R7
    run_op(2'd1, 1'b0, 32'h0001_0000, 32'h8, 8'd100, 80, 0);         // R4 clamp
    run_op(2'd1, 1'b0, 32'h0001_0000, 32'h8, 8'd64, 100, 0);         // R4 at max
    run_op(2'd3, 1'b1, 32'h0000_0200, 32'h99, 8'd6, 50, 0);          // R1 spare code
    run_op(2'd0, 1'b0, 32'h0000_3000, 32'h0, 8'd10, 40, 1);          // R9 poke
    run_op(2'd1, 1'b1, 32'h0000_0000, 32'h0, 8'd1, 20, 0);           // R2 zero stride, length 1

    for (int r = 0; r < 30; r++) begin
      if (r % 5 == 0) fill_idx();
      run_op(2'($urandom), 1'($urandom), $urandom, $urandom,
             8'($urandom_range(0, 80)), int'($urandom_range(20, 100)),
             1'($urandom_range(0, 3) == 0));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule